// File: doc/BRIEF.md
# Type-C Lane Configuration Controller

This block is the digital control core of a Type-C crosspoint redriver that takes its configuration from strap pins. It samples two direction pins, two mode pins, an orientation (flip) pin and a swap pin through a synchronizer. From them it decides the operating mode and, for each of the four high-speed channels, a route select, a lane enable, an equalizer-source select and an alternate-mode lane index. It also drives the power-down flag and the state of the AUX-to-sideband switch.

The four channels are numbered 0..3: channel 0 is the receive pair of connector pair 1, channel 1 the transmit pair of pair 1, channel 2 the transmit pair of pair 2 and channel 3 the receive pair of pair 2. The block comes out of reset in a sticky USB mode. The pins take over only after the low-mode pin has gone high and then low again. The sideband switch closes as soon as the high-mode pin is seen high. It opens only after that pin has stayed low for a programmable number of clock ticks. When the strap-mode input is low, all lane, sideband and power-down outputs take host-supplied values instead.

Top module: `lane_cfg_ctrl`

## Requirements
- R1: After reset, with all pins low and strap mode on, opMode reads 4 (sticky USB), routeSel is 8'h06, laneEn is 4'b0011, eqSel is 4'b0001, sbuSel is 0 and pwrDn is 0.
- R2: The sticky USB mode (opMode 4, routed as USB) ignores the mode pins until ctlLo has been seen rising and then falling. After that the pins alone set the mode, and code 4 never returns until the next reset.
- R3: After release, {ctlHi,ctlLo} = 00 gives opMode 0 (off), 01 gives 1 (USB only), 10 gives 2 (four alt lanes) and 11 gives 3 (USB plus two alt lanes).
- R4: In mode 0, for either flip value, pwrDn is 1 and routeSel, laneEn, eqSel and laneIdx are all zero.
- R5: Route codes are 00 idle, 01 upstream-to-downstream and 10 downstream-to-upstream, with channel c in routeSel[2c+1:2c]. A USB receive channel is 10 and a USB transmit channel is 01. Alternate lanes are 01, except the receive channels (0 and 3) in the custom family (dirSel[1]=1), which are 10. Unused channels are idle with their enable low.
- R6: The USB pair (and the pair that does not carry the two alt lanes) is pair 1 (channels 0,1) when flipPin XOR dirSel[0] is 0, and pair 2 (channels 2,3) otherwise.
- R7: laneIdx holds 2 bits per channel. In mode 2 with orientation 0, channels 3,2,1,0 carry lanes 0,1,2,3; with orientation 1, channel c carries lane c. In mode 3 the alt receive channel carries lane 0 and the alt transmit channel lane 1. All other channels read 0.
- R8: swapPin=1 exchanges codes 01 and 10 on every enabled channel. eqSel[c] is 1 (downstream setting) exactly when enabled channel c routes downstream-to-upstream, so it follows the swap.
- R9: While ctlHi is high the sideband switch is closed: sbuSel is 1 (straight) with flipPin low and 2 (crossed) with flipPin high.
- R10: When ctlHi goes low, sbuSel keeps its last closed value until ctlHi has been low for OPEN_TICKS clocks, then reads 0 (open). Any high interval restarts the count.
- R11: With strapMode low, routeSel, laneEn, eqSel, laneIdx, sbuSel and pwrDn equal the host inputs.
- R12: A pin change driven between clock edges appears at the outputs on the third rising edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strapMode | input | 1 | High selects pin-strap configuration |
| dirSel | input | 2 | [1] alt family (0 display, 1 custom), [0] side (0 source, 1 sink) |
| ctlHi | input | 1 | Upper mode pin |
| ctlLo | input | 1 | Lower mode pin |
| flipPin | input | 1 | Connector orientation |
| swapPin | input | 1 | Reverse all lane directions |
| hostRoute | input | 8 | Host route selects |
| hostLaneEn | input | 4 | Host lane enables |
| hostEqSel | input | 4 | Host equalizer-source selects |
| hostLaneIdx | input | 8 | Host lane indices |
| hostSbu | input | 2 | Host sideband switch state |
| hostPwrDn | input | 1 | Host power-down flag |
| routeSel | output | 8 | Per-channel route select |
| laneEn | output | 4 | Per-channel lane enable |
| eqSel | output | 4 | Per-channel equalizer source (1 = downstream) |
| laneIdx | output | 8 | Per-channel alternate lane index |
| sbuSel | output | 2 | Sideband switch: 0 open, 1 straight, 2 crossed |
| pwrDn | output | 1 | Power-down flag |
| opMode | output | 3 | Decoded operating mode |

## Verification
The sticky-default release and the pin decode meet in one cycle: the edge that sees ctlLo fall also hands the mode over to the pins. The bench provokes this by holding ctlHi high through the pulse and expects four-lane alt routing right after the fall. The sideband timer expiring and the mode pins changing can also coincide. The bench starts a low interval, raises ctlHi briefly partway through, and judges that the switch stays closed until a full fresh interval has passed. Random pin patterns are compared against a bench model of the routing rules.

// File: rtl/lane_cfg_pkg.sv
package lane_cfg_pkg;
  localparam int NUM_CH = 4;
  localparam int RT_W   = 2;
  localparam int IDX_W  = 2;
  localparam int ROUTE_BUS_W = NUM_CH * RT_W;
  localparam int IDX_BUS_W   = NUM_CH * IDX_W;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_USB      = 3'd1,
    MODE_ALT4     = 3'd2,
    MODE_USB_ALT2 = 3'd3,
    MODE_BOOT     = 3'd4
  } op_mode_e;

  localparam logic [RT_W-1:0] RT_IDLE  = 2'b00;
  localparam logic [RT_W-1:0] RT_UP2DN = 2'b01;
  localparam logic [RT_W-1:0] RT_DN2UP = 2'b10;

  localparam logic [1:0] SBU_OPEN     = 2'd0;
  localparam logic [1:0] SBU_STRAIGHT = 2'd1;
  localparam logic [1:0] SBU_CROSSED  = 2'd2;

  // strobes from control to the lane datapath
  typedef struct packed {
    op_mode_e   mode;
    logic       orient;
    logic       swap;
    logic       custom;
    logic       strap;
    logic [1:0] sbu;
  } ctrl_t;
endpackage

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lane_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OPEN_TICKS  = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapIn,
  input  logic [1:0] dirIn,
  input  logic       ctlHiIn,
  input  logic       ctlLoIn,
  input  logic       flipIn,
  input  logic       swapIn,
  output ctrl_t      cfg,
  output logic       ctlHiSync
);
  localparam int PIN_W = 7;
  localparam int CNT_W = $clog2(OPEN_TICKS + 1);
  localparam logic [PIN_W-1:0] PIN_RST = 7'b100_0000;

  logic [PIN_W-1:0] pinVec;
  logic [PIN_W-1:0] syncQ [SYNC_STAGES];

  assign pinVec = {strapIn, dirIn, ctlHiIn, ctlLoIn, flipIn, swapIn};

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= PIN_RST;
        else if (s == 0) syncQ[s] <= pinVec;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  logic       strapS, ctlHiS, ctlLoS, flipS, swapS;
  logic [1:0] dirS;
  assign {strapS, dirS, ctlHiS, ctlLoS, flipS, swapS} = syncQ[SYNC_STAGES-1];

  // sticky power-up USB state
  logic bootUsb, riseSeen, ctlLoPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootUsb   <= 1'b1;
      riseSeen  <= 1'b0;
      ctlLoPrev <= 1'b0;
    end else begin
      ctlLoPrev <= ctlLoS;
      if (ctlLoS && !ctlLoPrev) riseSeen <= 1'b1;
      if (riseSeen && ctlLoPrev && !ctlLoS) bootUsb <= 1'b0;
    end
  end

  // sideband switch with low-time filter
  logic [CNT_W-1:0] lowCnt;
  logic [1:0]       sbuQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      sbuQ   <= SBU_OPEN;
    end else if (ctlHiS) begin
      lowCnt <= '0;
      sbuQ   <= flipS ? SBU_CROSSED : SBU_STRAIGHT;
    end else if (lowCnt == CNT_W'(OPEN_TICKS)) begin
      sbuQ   <= SBU_OPEN;
    end else begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  op_mode_e pinMode;
  always_comb begin
    unique case ({ctlHiS, ctlLoS})
      2'b00:   pinMode = MODE_OFF;
      2'b01:   pinMode = MODE_USB;
      2'b10:   pinMode = MODE_ALT4;
      default: pinMode = MODE_USB_ALT2;
    endcase
  end

  always_comb begin
    cfg.mode   = bootUsb ? MODE_BOOT : pinMode;
    cfg.orient = flipS ^ dirS[0];
    cfg.swap   = swapS;
    cfg.custom = dirS[1];
    cfg.strap  = strapS;
    cfg.sbu    = sbuQ;
  end

  assign ctlHiSync = ctlHiS;
endmodule

// File: rtl/lcc_lanes.sv
module lcc_lanes
  import lane_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_t                  cfg,
  input  logic [ROUTE_BUS_W-1:0] hostRoute,
  input  logic [NUM_CH-1:0]      hostLaneEn,
  input  logic [NUM_CH-1:0]      hostEqSel,
  input  logic [IDX_BUS_W-1:0]   hostLaneIdx,
  input  logic [1:0]             hostSbu,
  input  logic                   hostPwrDn,
  output logic [ROUTE_BUS_W-1:0] routeSel,
  output logic [NUM_CH-1:0]      laneEn,
  output logic [NUM_CH-1:0]      eqSel,
  output logic [IDX_BUS_W-1:0]   laneIdx,
  output logic [1:0]             sbuSel,
  output logic                   pwrDn,
  output logic [2:0]             opMode
);
  logic [ROUTE_BUS_W-1:0] nxtRoute;
  logic [NUM_CH-1:0]      nxtEn, nxtEq;
  logic [IDX_BUS_W-1:0]   nxtIdx;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam bit IS_RX = (c == 0) || (c == NUM_CH-1);
      localparam bit PAIR2 = (c >= NUM_CH/2);
      localparam logic [IDX_W-1:0] IDX_FWD = IDX_W'(c);
      localparam logic [IDX_W-1:0] IDX_REV = IDX_W'(NUM_CH-1-c);

      logic            onUsb, en;
      logic [RT_W-1:0] usbRt, altRt, baseRt, rt;
      logic [IDX_W-1:0] idx;

      assign onUsb = (PAIR2 == cfg.orient);
      assign usbRt = IS_RX ? RT_DN2UP : RT_UP2DN;
      assign altRt = (cfg.custom && IS_RX) ? RT_DN2UP : RT_UP2DN;

      always_comb begin
        en = 1'b0;
        baseRt = RT_IDLE;
        idx = '0;
        unique case (cfg.mode)
          MODE_USB, MODE_BOOT: begin
            en = onUsb;
            baseRt = onUsb ? usbRt : RT_IDLE;
          end
          MODE_ALT4: begin
            en = 1'b1;
            baseRt = altRt;
            idx = cfg.orient ? IDX_FWD : IDX_REV;
          end
          MODE_USB_ALT2: begin
            en = 1'b1;
            baseRt = onUsb ? usbRt : altRt;
            idx = (onUsb || IS_RX) ? IDX_W'(0) : IDX_W'(1);
          end
          default: ;
        endcase
        rt = (en && cfg.swap) ? ~baseRt : baseRt;
      end

      assign nxtRoute[c*RT_W +: RT_W]   = rt;
      assign nxtIdx[c*IDX_W +: IDX_W]   = idx;
      assign nxtEn[c]                   = en;
      assign nxtEq[c]                   = en && (rt == RT_DN2UP);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeSel <= '0;
      laneEn   <= '0;
      eqSel    <= '0;
      laneIdx  <= '0;
      sbuSel   <= SBU_OPEN;
      pwrDn    <= 1'b0;
      opMode   <= MODE_BOOT;
    end else begin
      opMode <= cfg.mode;
      if (cfg.strap) begin
        routeSel <= nxtRoute;
        laneEn   <= nxtEn;
        eqSel    <= nxtEq;
        laneIdx  <= nxtIdx;
        sbuSel   <= cfg.sbu;
        pwrDn    <= (cfg.mode == MODE_OFF);
      end else begin
        routeSel <= hostRoute;
        laneEn   <= hostLaneEn;
        eqSel    <= hostEqSel;
        laneIdx  <= hostLaneIdx;
        sbuSel   <= hostSbu;
        pwrDn    <= hostPwrDn;
      end
    end
  end
endmodule

// File: rtl/lane_cfg_ctrl.sv
module lane_cfg_ctrl
  import lane_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OPEN_TICKS  = 250000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   strapMode,
  input  logic [1:0]             dirSel,
  input  logic                   ctlHi,
  input  logic                   ctlLo,
  input  logic                   flipPin,
  input  logic                   swapPin,
  input  logic [ROUTE_BUS_W-1:0] hostRoute,
  input  logic [NUM_CH-1:0]      hostLaneEn,
  input  logic [NUM_CH-1:0]      hostEqSel,
  input  logic [IDX_BUS_W-1:0]   hostLaneIdx,
  input  logic [1:0]             hostSbu,
  input  logic                   hostPwrDn,
  output logic [ROUTE_BUS_W-1:0] routeSel,
  output logic [NUM_CH-1:0]      laneEn,
  output logic [NUM_CH-1:0]      eqSel,
  output logic [IDX_BUS_W-1:0]   laneIdx,
  output logic [1:0]             sbuSel,
  output logic                   pwrDn,
  output logic [2:0]             opMode
);
  ctrl_t ctrlBus;
  logic  ctlHiNow;

  lcc_ctrl #(.SYNC_STAGES(SYNC_STAGES), .OPEN_TICKS(OPEN_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapIn(strapMode), .dirIn(dirSel),
    .ctlHiIn(ctlHi), .ctlLoIn(ctlLo), .flipIn(flipPin), .swapIn(swapPin),
    .cfg(ctrlBus), .ctlHiSync(ctlHiNow)
  );

  lcc_lanes u_lanes (
    .clk(clk), .rstN(rstN), .cfg(ctrlBus),
    .hostRoute(hostRoute), .hostLaneEn(hostLaneEn), .hostEqSel(hostEqSel),
    .hostLaneIdx(hostLaneIdx), .hostSbu(hostSbu), .hostPwrDn(hostPwrDn),
    .routeSel(routeSel), .laneEn(laneEn), .eqSel(eqSel), .laneIdx(laneIdx),
    .sbuSel(sbuSel), .pwrDn(pwrDn), .opMode(opMode)
  );
endmodule

// File: rtl/lcc_chk.sv
module lcc_chk
  import lane_cfg_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   strapNow,
  input logic                   ctlHiNow,
  input logic [1:0]             sbuNow,
  input logic [ROUTE_BUS_W-1:0] routeSel,
  input logic [NUM_CH-1:0]      laneEn,
  input logic [NUM_CH-1:0]      eqSel,
  input logic                   pwrDn,
  input logic [2:0]             opMode
);
  // R4
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strapNow) && pwrDn) |-> (laneEn == '0 && routeSel == '0 && eqSel == '0));

  // R3
  pd_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strapNow) |-> (pwrDn == (opMode == MODE_OFF)));

  // R5
  lane_pairs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strapNow) |-> ($countones(laneEn) != 1 && $countones(laneEn) != 3));

  // R2
  boot_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != MODE_BOOT) |=> (opMode != MODE_BOOT));

  // R9
  sbu_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sbuNow != SBU_OPEN && $past(sbuNow) == SBU_OPEN) |-> $past(ctlHiNow));

  // R10
  sbu_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sbuNow == SBU_OPEN && $past(sbuNow) != SBU_OPEN) |-> !$past(ctlHiNow));

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_eq
      // R8
      eq_side_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(strapNow) |-> (eqSel[c] == (laneEn[c] && routeSel[c*RT_W +: RT_W] == RT_DN2UP)));
    end
  endgenerate
endmodule

bind lane_cfg_ctrl lcc_chk u_chk (
  .clk(clk), .rstN(rstN), .strapNow(ctrlBus.strap), .ctlHiNow(ctlHiNow),
  .sbuNow(ctrlBus.sbu), .routeSel(routeSel), .laneEn(laneEn), .eqSel(eqSel),
  .pwrDn(pwrDn), .opMode(opMode)
);

// File: tb/tb_lane_cfg_ctrl.sv
module tb_lane_cfg_ctrl;
  localparam int TICKS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapMode = 1'b1;
  logic [1:0] dirSel = 2'b00;
  logic ctlHi = 1'b0, ctlLo = 1'b0, flipPin = 1'b0, swapPin = 1'b0;
  logic [7:0] hostRoute = '0, hostLaneIdx = '0;
  logic [3:0] hostLaneEn = '0, hostEqSel = '0;
  logic [1:0] hostSbu = '0;
  logic hostPwrDn = 1'b0;
  logic [7:0] routeSel, laneIdx;
  logic [3:0] laneEn, eqSel;
  logic [1:0] sbuSel;
  logic pwrDn;
  logic [2:0] opMode;

  int checks = 0;
  int errors = 0;
  bit bootModel = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_cfg_ctrl #(.SYNC_STAGES(2), .OPEN_TICKS(TICKS)) dut (
    .clk(clk), .rstN(rstN), .strapMode(strapMode), .dirSel(dirSel),
    .ctlHi(ctlHi), .ctlLo(ctlLo), .flipPin(flipPin), .swapPin(swapPin),
    .hostRoute(hostRoute), .hostLaneEn(hostLaneEn), .hostEqSel(hostEqSel),
    .hostLaneIdx(hostLaneIdx), .hostSbu(hostSbu), .hostPwrDn(hostPwrDn),
    .routeSel(routeSel), .laneEn(laneEn), .eqSel(eqSel), .laneIdx(laneIdx),
    .sbuSel(sbuSel), .pwrDn(pwrDn), .opMode(opMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns {laneIdx, routeSel, laneEn, eqSel}
  function automatic logic [23:0] model(input logic [1:0] d, input logic c1, input logic c0,
                                        input logic fl, input logic sw, input bit boot);
    logic [1:0] r [4];
    logic [1:0] ix [4];
    logic [3:0] en, eq;
    int md, p, rx, tx;
    md = boot ? 4 : int'({c1, c0});
    p = int'(fl ^ d[0]);
    en = '0; eq = '0;
    for (int k = 0; k < 4; k++) begin r[k] = 2'd0; ix[k] = 2'd0; end
    if (md == 1 || md == 3 || md == 4) begin
      rx = p ? 3 : 0; tx = p ? 2 : 1;
      r[rx] = 2'd2; r[tx] = 2'd1; en[rx] = 1'b1; en[tx] = 1'b1;
    end
    if (md == 2) begin
      for (int k = 0; k < 4; k++) begin
        r[k] = (d[1] && (k == 0 || k == 3)) ? 2'd2 : 2'd1;
        ix[k] = 2'(p ? k : 3 - k);
      end
      en = 4'hF;
    end
    if (md == 3) begin
      rx = p ? 0 : 3; tx = p ? 1 : 2;
      r[rx] = d[1] ? 2'd2 : 2'd1; r[tx] = 2'd1;
      ix[rx] = 2'd0; ix[tx] = 2'd1;
      en[rx] = 1'b1; en[tx] = 1'b1;
    end
    for (int k = 0; k < 4; k++) begin
      if (en[k] && sw) r[k] = (r[k] == 2'd1) ? 2'd2 : 2'd1;
      eq[k] = en[k] && (r[k] == 2'd2);
    end
    return {ix[3], ix[2], ix[1], ix[0], r[3], r[2], r[1], r[0], en, eq};
  endfunction

  function automatic logic [2:0] expMode(input logic c1, input logic c0, input bit boot);
    return boot ? 3'd4 : {1'b0, c1, c0};
  endfunction

  task automatic chkLanes(input string tagR, input string tagE, input string tagI);
    logic [23:0] e;
    e = model(dirSel, ctlHi, ctlLo, flipPin, swapPin, bootModel);
    chk(tagR, {24'd0, routeSel}, {24'd0, e[15:8]});
    chk(tagR, {28'd0, laneEn}, {28'd0, e[7:4]});
    chk(tagE, {28'd0, eqSel}, {28'd0, e[3:0]});
    chk(tagI, {24'd0, laneIdx}, {24'd0, e[23:16]});
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1C3A);
    step(3);
    rstN = 1'b1;
    step(6);

    // R1 reset state
    chk("R1 opMode", {29'd0, opMode}, 32'd4);
    chk("R1 routeSel", {24'd0, routeSel}, 32'h06);
    chk("R1 laneEn", {28'd0, laneEn}, 32'h3);
    chk("R1 eqSel", {28'd0, eqSel}, 32'h1);
    chk("R1 sbuSel", {30'd0, sbuSel}, 32'd0);
    chk("R1 pwrDn", {31'd0, pwrDn}, 32'd0);

    // R2 sticky mode ignores pins until the ctlLo pulse
    ctlHi = 1'b1; step(6);
    chk("R2 held before pulse", {29'd0, opMode}, 32'd4);
    chk("R2 held routeSel", {24'd0, routeSel}, 32'h06);
    ctlLo = 1'b1; step(6);
    chk("R2 held after rise", {29'd0, opMode}, 32'd4);
    ctlLo = 1'b0; step(6);
    bootModel = 1'b0;
    chk("R2 released to pins", {29'd0, opMode}, 32'd2);
    chkLanes("R2 R5 alt4 route", "R8 eq", "R7 alt4 idx");
    chk("R9 straight", {30'd0, sbuSel}, 32'd1);

    // R12 latency: visible on third edge, not second
    ctlHi = 1'b0; ctlLo = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R12 not after two edges", {29'd0, opMode}, 32'd2);
    @(posedge clk); @(negedge clk);
    chk("R12 after three edges", {29'd0, opMode}, 32'd1);

    // R6 orientation
    flipPin = 1'b1; step(6);
    chk("R6 flip usb pair2", {24'd0, routeSel}, 32'h90);
    dirSel = 2'b01; flipPin = 1'b0; step(6);
    chk("R6 sink usb pair2", {24'd0, routeSel}, 32'h90);
    dirSel = 2'b00;

    // R8 swap
    swapPin = 1'b1; step(6);
    chk("R8 swap route", {24'd0, routeSel}, 32'h09);
    chk("R8 swap eq", {28'd0, eqSel}, 32'h2);
    swapPin = 1'b0;

    // R7 four-lane index order
    ctlHi = 1'b1; ctlLo = 1'b0; step(6);
    chk("R7 idx orient0", {24'd0, laneIdx}, 32'h1B);
    flipPin = 1'b1; step(6);
    chk("R7 idx orient1", {24'd0, laneIdx}, 32'hE4);
    chk("R9 crossed", {30'd0, sbuSel}, 32'd2);

    // R4 power-down with both flip values, R10 hold then open
    ctlHi = 1'b0; step(6);
    chk("R4 pwrDn flip1", {31'd0, pwrDn}, 32'd1);
    chk("R4 idle flip1", {12'd0, laneIdx, routeSel, laneEn, eqSel}, 32'd0);
    chk("R3 off code", {29'd0, opMode}, 32'd0);
    flipPin = 1'b0; step(6);
    chk("R4 pwrDn flip0", {31'd0, pwrDn}, 32'd1);
    chk("R4 idle flip0", {12'd0, laneIdx, routeSel, laneEn, eqSel}, 32'd0);
    step(TICKS - 22);
    chk("R10 still closed", {30'd0, sbuSel}, 32'd2);
    step(20);
    chk("R10 opened", {30'd0, sbuSel}, 32'd0);

    // R10 restart by a short high interval
    ctlHi = 1'b1; step(6);
    ctlHi = 1'b0; step(TICKS - 10);
    ctlHi = 1'b1; step(3);
    ctlHi = 1'b0; step(TICKS - 10);
    chk("R10 restart keeps closed", {30'd0, sbuSel}, 32'd1);
    step(20);
    chk("R10 open after restart", {30'd0, sbuSel}, 32'd0);

    // R11 host-driven outputs
    hostRoute = 8'hA5; hostLaneEn = 4'h9; hostEqSel = 4'h6;
    hostLaneIdx = 8'h3C; hostSbu = 2'd2; hostPwrDn = 1'b1;
    strapMode = 1'b0; step(6);
    chk("R11 host route", {24'd0, routeSel}, 32'hA5);
    chk("R11 host en/eq", {24'd0, laneEn, eqSel}, 32'h96);
    chk("R11 host idx", {24'd0, laneIdx}, 32'h3C);
    chk("R11 host sbu/pd", {29'd0, sbuSel, pwrDn}, 32'h5);
    strapMode = 1'b1;

    // random patterns
    for (int i = 0; i < 300; i++) begin
      dirSel  = 2'($urandom);
      ctlHi   = 1'($urandom);
      ctlLo   = 1'($urandom);
      flipPin = 1'($urandom);
      swapPin = 1'($urandom);
      step(6);
      chk("R3 mode", {29'd0, opMode}, {29'd0, expMode(ctlHi, ctlLo, 1'b0)});
      chk("R4 pwrDn", {31'd0, pwrDn}, {31'd0, (ctlHi == 1'b0 && ctlLo == 1'b0)});
      chkLanes("R5 R6 route", "R8 eq", "R7 idx");
      if (ctlHi) chk("R9 sbu", {30'd0, sbuSel}, flipPin ? 32'd2 : 32'd1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule